// File: doc/BRIEF.md
# Oversampling Accumulate, Shift and Round Unit

This block sits behind a 12-bit converter and turns a burst of consecutive samples into one wider, lower-noise result. Each time the sample strobe is high while the unit is enabled, the sample is added to a running sum, so the converter's own timing is unchanged. When the number of samples chosen by the ratio code has been collected, the sum is shifted right by the amount chosen by the shift code and rounded to nearest. Only the low 16 bits of that value are kept, and they come out with a one-cycle valid pulse.

Large ratios combined with small shifts produce sums wider than 16 bits. These are not saturated: the upper bits are dropped and the result wraps. Clearing the enable throws away any partial batch. The ratio and shift codes must be held steady while a batch is in progress.

Top module: `adc_ovs_unit`

## Requirements
- R1: While reset is high, and in the cycle after it, res_vld is 0 and result is 0x0000.
- R2: Ratio code k (0..7) selects a batch of 2^(k+1) accepted samples. A sample is accepted when smp_vld and en are both 1. Each batch produces exactly one res_vld pulse, one clock wide, in the cycle after the batch's last sample is accepted.
- R3: For a shift code s in 0..8, result equals bits [15:0] of (S + H) >> s. S is the exact sum of the batch, H is 2^(s-1) when s > 0, and H is 0 when s = 0.
- R4: Rounding is to nearest, and an exact half rounds up. Two samples of value 1 with shift code 2 give 0x0001.
- R5: Shift codes 9 to 15 behave exactly like shift code 8.
- R6: The sum never overflows internally. 256 full-scale samples (0xFFF) give 0xFF00 with shift 0 and 0x0FFF with shift 8. 32 full-scale samples with shift 0 give 0xFFE0. Two full-scale samples with shift 2 give 0x0800. 256 samples summing to 0xB737D with shift 5 give 0x5B9C.
- R7: When en is 0, samples are ignored and no pulse is produced. Any partial batch is discarded, so the next batch after en returns holds only samples accepted after that point.
- R8: Cycles with smp_vld low are not counted. Samples may arrive on every clock, including the first sample of a new batch in the cycle right after the previous batch's last sample. None is lost.
- R9: result keeps its value in every cycle in which res_vld is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Oversampling enable; low clears the partial batch |
| ratio_code | input | 3 | Batch size code, k selects 2^(k+1) samples |
| shift_code | input | 4 | Right-shift amount, 0..8; larger values are treated as 8 |
| smp_vld | input | 1 | Sample strobe |
| smp_data | input | 12 | Converter sample |
| res_vld | output | 1 | One-cycle pulse marking a new result |
| result | output | 16 | Shifted, rounded and truncated batch result |

## Verification
All-full-scale streams are run over every ratio and shift pair. They expose wrap-around in the truncation, a missing top accumulator bit, and the clamp on shift codes. All-zero streams show that the rounding constant is not added when there is nothing to round. Random streams run over the same grid and catch errors in the rounding position or in the batch count that full-scale data might hide.

Several directed streams cover the remaining behaviour. Near-half sums check that ties round up. A crafted 256-sample stream hits one exact known value. Gapped, back-to-back and interrupted-enable streams show how samples are counted, how a batch joins the next one, and that a partial batch is discarded.

// File: rtl/adc_ovs_pkg.sv
package adc_ovs_pkg;
  localparam int SMP_W     = 12;
  localparam int RES_W     = 16;
  localparam int RATIO_W   = 3;
  localparam int SHIFT_W   = 4;
  localparam int MAX_SHIFT = 8;
  // largest batch is 2^(2^RATIO_W) samples
  localparam int CNT_W     = 1 << RATIO_W;
  localparam int ACC_W     = SMP_W + CNT_W;
endpackage

// File: rtl/ovs_batch_ctr.sv
module ovs_batch_ctr
  import adc_ovs_pkg::*;
#(
  parameter int RW = RATIO_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          take,
  input  logic [RW-1:0] ratio_code,
  output logic          last
);
  logic [CW-1:0] cnt_q;
  logic [CW:0]   last_idx;
  logic [RW:0]   exp_w;

  always_comb begin
    exp_w    = {1'b0, ratio_code} + {{RW{1'b0}}, 1'b1};
    last_idx = ({{CW{1'b0}}, 1'b1} << exp_w) - {{CW{1'b0}}, 1'b1};
    last     = take && ({1'b0, cnt_q} == last_idx);
  end

  always_ff @(posedge clk) begin
    if (rst || !en || last) cnt_q <= '0;
    else if (take)          cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ovs_accum.sv
module ovs_accum
  import adc_ovs_pkg::*;
#(
  parameter int SW = SMP_W,
  parameter int AW = ACC_W
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          take,
  input  logic [SW-1:0] data,
  output logic [AW-1:0] sum_next
);
  logic [AW-1:0] acc_q;

  // the sum including the current sample, used when it closes a batch
  always_comb begin
    sum_next = acc_q + (take ? {{(AW-SW){1'b0}}, data} : '0);
  end

  always_ff @(posedge clk) begin
    if (clr)       acc_q <= '0;
    else if (take) acc_q <= sum_next;
  end
endmodule

// File: rtl/ovs_round_shift.sv
module ovs_round_shift
  import adc_ovs_pkg::*;
#(
  parameter int AW   = ACC_W,
  parameter int OW   = RES_W,
  parameter int SHW  = SHIFT_W,
  parameter int MAXS = MAX_SHIFT
) (
  input  logic [AW-1:0]  sum,
  input  logic [SHW-1:0] shift_code,
  output logic [OW-1:0]  res
);
  localparam int WW = AW + 1;
  localparam logic [SHW-1:0] SH_MAX = SHW'(MAXS);

  logic [SHW-1:0] sh;
  logic [WW-1:0]  half;
  logic [WW-1:0]  biased;
  logic [WW-1:0]  shifted;

  always_comb begin
    sh = (shift_code > SH_MAX) ? SH_MAX : shift_code;
    if (sh == '0) half = '0;
    else          half = {{(WW-1){1'b0}}, 1'b1} << (sh - 1'b1);
    biased  = {1'b0, sum} + half;
    shifted = biased >> sh;
  end

  generate
    if (WW >= OW) begin : g_trunc
      assign res = shifted[OW-1:0];
    end else begin : g_pad
      assign res = {{(OW-WW){1'b0}}, shifted};
    end
  endgenerate
endmodule

// File: rtl/adc_ovs_unit.sv
module adc_ovs_unit
  import adc_ovs_pkg::*;
#(
  parameter int SW   = SMP_W,
  parameter int OW   = RES_W,
  parameter int RW   = RATIO_W,
  parameter int SHW  = SHIFT_W,
  parameter int MAXS = MAX_SHIFT
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic [RW-1:0]  ratio_code,
  input  logic [SHW-1:0] shift_code,
  input  logic           smp_vld,
  input  logic [SW-1:0]  smp_data,
  output logic           res_vld,
  output logic [OW-1:0]  result
);
  localparam int CW = 1 << RW;
  localparam int AW = SW + CW;

  logic          take;
  logic          last;
  logic [AW-1:0] sum_next;
  logic [OW-1:0] res_d;

  assign take = en && smp_vld;

  ovs_batch_ctr #(.RW(RW), .CW(CW)) u_ctr (
    .clk(clk), .rst(rst), .en(en), .take(take),
    .ratio_code(ratio_code), .last(last)
  );

  ovs_accum #(.SW(SW), .AW(AW)) u_acc (
    .clk(clk), .clr(rst || !en || last), .take(take),
    .data(smp_data), .sum_next(sum_next)
  );

  ovs_round_shift #(.AW(AW), .OW(OW), .SHW(SHW), .MAXS(MAXS)) u_rs (
    .sum(sum_next), .shift_code(shift_code), .res(res_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_vld <= 1'b0;
      result  <= '0;
    end else begin
      res_vld <= last;
      if (last) result <= res_d;
    end
  end
endmodule

// File: rtl/adc_ovs_unit_chk.sv
module adc_ovs_unit_chk #(
  parameter int RW = 3,
  parameter int SHW = 4,
  parameter int OW = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           en,
  input logic [RW-1:0]  ratio_code,
  input logic [SHW-1:0] shift_code,
  input logic           smp_vld,
  input logic           res_vld,
  input logic [OW-1:0]  result
);
  localparam int CW = 1 << RW;

  logic          rst_q = 1'b0;
  logic [CW:0]   seen;
  logic [CW:0]   batch_n;
  logic [RW:0]   exp_w;

  always_comb begin
    exp_w   = {1'b0, ratio_code} + {{RW{1'b0}}, 1'b1};
    batch_n = {{CW{1'b0}}, 1'b1} << exp_w;
  end

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst || !en)   seen <= '0;
    else if (res_vld) seen <= {{CW{1'b0}}, smp_vld};
    else if (smp_vld) seen <= seen + 1'b1;
  end

  // R1: outputs cleared right after a reset edge
  always @(negedge clk) begin
    if (rst_q) a_r1_reset_clear: assert (!res_vld && result == '0);
  end

  // R2: a pulse follows an accepted sample
  a_r2_after_sample: assert property (@(posedge clk) disable iff (rst)
    res_vld |-> $past(en && smp_vld));

  // R2: pulse marks exactly a full batch
  a_r2_batch_len: assert property (@(posedge clk) disable iff (rst)
    res_vld |-> seen == batch_n);

  // R2: pulse is one cycle wide
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    res_vld |=> !res_vld);

  // R7: no pulse after a disabled cycle
  a_r7_no_pulse_off: assert property (@(posedge clk) disable iff (rst)
    !$past(en) |-> !res_vld);

  // R9: result held between pulses
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !res_vld |-> $stable(result));

  // R5 R6: clamp at 8 bits of shift bounds the result
  a_r6_shift8_bound: assert property (@(posedge clk) disable iff (rst)
    (res_vld && $past(shift_code) >= SHW'(8)) |-> result <= 16'h0FFF);
endmodule

bind adc_ovs_unit adc_ovs_unit_chk #(.RW(RW), .SHW(SHW), .OW(OW)) u_chk (
  .clk(clk), .rst(rst), .en(en), .ratio_code(ratio_code),
  .shift_code(shift_code), .smp_vld(smp_vld), .res_vld(res_vld),
  .result(result)
);

// File: tb/adc_ovs_unit_bench.sv
module adc_ovs_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [2:0]  ratio_code = '0;
  logic [3:0]  shift_code = '0;
  logic        smp_vld = 1'b0;
  logic [11:0] smp_data = '0;
  logic        res_vld;
  logic [15:0] result;

  int n_checks = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  adc_ovs_unit u_adc_ovs_unit (
    .clk(clk), .rst(rst), .en(en), .ratio_code(ratio_code),
    .shift_code(shift_code), .smp_vld(smp_vld), .smp_data(smp_data),
    .res_vld(res_vld), .result(result)
  );

  function automatic logic [15:0] model(input longint sum, input int sc);
    int s;
    longint v;
    s = (sc > 8) ? 8 : sc;
    v = sum + ((s > 0) ? (64'd1 << (s - 1)) : 0);
    return 16'(v >> s);
  endfunction

  task automatic check(input string req, input bit ok, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // mode: 0 full scale, 1 zero, 2 random, 3 first=v0 rest=v1
  task automatic run_batch(input int k, input int sc, input int mode,
                           input int v0, input int v1, input string req,
                           input bit exp_given, input logic [15:0] exp_val);
    longint sum = 0;
    int n = 1 << (k + 1);
    bit early = 0;
    @(negedge clk);
    en = 1; ratio_code = 3'(k); shift_code = 4'(sc);
    for (int i = 0; i < n; i++) begin
      int d;
      case (mode)
        0: d = 12'hFFF;
        1: d = 0;
        2: d = int'($urandom_range(0, 4095));
        default: d = (i == 0) ? v0 : v1;
      endcase
      sum += d;
      smp_vld = 1; smp_data = 12'(d);
      @(negedge clk);
      if (i < n - 1 && res_vld) early = 1;
    end
    smp_vld = 0;
    check({req, " R2 pulse"}, res_vld == 1'b1 && !early, longint'(res_vld), 1);
    if (exp_given) check({req, " value"}, result == exp_val, result, exp_val);
    else           check({req, " R3 value"}, result == model(sum, sc), result, model(sum, sc));
    @(negedge clk);
    check("R2 R9 one-cycle pulse, held value", !res_vld &&
          (exp_given ? result == exp_val : result == model(sum, sc)), longint'(res_vld), 0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check("R1 reset valid", res_vld == 1'b0, longint'(res_vld), 0);
    check("R1 reset result", result == 16'h0, result, 0);
    rst = 0;
    @(negedge clk);
    check("R1 after reset", res_vld == 1'b0 && result == 16'h0, result, 0);
  endtask

  task automatic t_grid;
    for (int k = 0; k < 8; k++)
      for (int sc = 0; sc < 16; sc++) begin
        run_batch(k, sc, 0, 0, 0, "R3 R5 R6 full-scale", 0, 16'h0);
        run_batch(k, sc, 1, 0, 0, "R3 zero", 0, 16'h0);
        run_batch(k, sc, 2, 0, 0, "R3 R5 random", 0, 16'h0);
      end
  endtask

  task automatic t_known;
    run_batch(0, 2, 0, 0, 0, "R6 2x sh2", 1, 16'h0800);
    run_batch(4, 0, 0, 0, 0, "R6 32x sh0", 1, 16'hFFE0);
    run_batch(7, 0, 0, 0, 0, "R6 256x sh0", 1, 16'hFF00);
    run_batch(7, 8, 0, 0, 0, "R6 256x sh8", 1, 16'h0FFF);
    run_batch(7, 15, 0, 0, 0, "R5 256x code15", 1, 16'h0FFF);
    run_batch(7, 5, 3, 3056, 2931, "R6 0xB737D sh5", 1, 16'h5B9C);
    run_batch(0, 2, 3, 1, 1, "R4 tie up", 1, 16'h0001);
    run_batch(0, 2, 3, 1, 0, "R4 below half", 1, 16'h0000);
    run_batch(0, 1, 3, 1, 0, "R4 tie sh1", 1, 16'h0001);
  endtask

  task automatic t_gaps;
    // 4x with idle cycles between samples: 10+20+30+40 = 100
    @(negedge clk);
    en = 1; ratio_code = 3'd1; shift_code = 4'd0;
    for (int i = 1; i <= 4; i++) begin
      smp_vld = 1; smp_data = 12'(10 * i);
      @(negedge clk);
      smp_vld = 0;
      repeat (2) begin
        @(negedge clk);
        if (i < 4) check("R8 no pulse during gaps", !res_vld, longint'(res_vld), 0);
      end
    end
    // pulse came one cycle after last sample, now held
    check("R8 gapped sum", result == 16'd100, result, 100);
  endtask

  task automatic t_back2back;
    // two 2x batches with no idle cycle: (5+7), then (100+200)
    @(negedge clk);
    en = 1; ratio_code = 3'd0; shift_code = 4'd0;
    smp_vld = 1; smp_data = 12'd5;
    @(negedge clk); smp_data = 12'd7;
    @(negedge clk); smp_data = 12'd100;
    check("R8 first batch pulse", res_vld && result == 16'd12, result, 12);
    @(negedge clk); smp_data = 12'd200;
    check("R8 no pulse mid batch", !res_vld, longint'(res_vld), 0);
    @(negedge clk); smp_vld = 0;
    check("R8 second batch", res_vld && result == 16'd300, result, 300);
  endtask

  task automatic t_enable;
    // partial batch of 3 then disable, strobes while off, then fresh 4x batch
    @(negedge clk);
    en = 1; ratio_code = 3'd1; shift_code = 4'd0;
    smp_vld = 1; smp_data = 12'd1000;
    repeat (3) @(negedge clk);
    en = 0; smp_data = 12'd2000;
    repeat (3) begin
      @(negedge clk);
      check("R7 no pulse while disabled", !res_vld, longint'(res_vld), 0);
    end
    check("R7 result untouched while off", result == 16'd300, result, 300);
    en = 1; smp_data = 12'd1;
    repeat (3) @(negedge clk);
    check("R7 no pulse on stale count", !res_vld, longint'(res_vld), 0);
    @(negedge clk); smp_vld = 0;
    check("R7 discarded partial batch", res_vld && result == 16'd4, result, 4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    t_reset();
    t_known();
    t_gaps();
    t_back2back();
    t_enable();
    t_grid();
    repeat (3) @(negedge clk);
    report();
  end
endmodule